// File: doc/BRIEF.md
# CAN Bit-Stream Destuffer

This block sits between the bit sampler of a CAN receiver and its field parser. For each raw bit that the sampler takes off the bus, it gets a valid strobe and the bit value. It decides whether that bit is a real frame bit or an inserted stuff bit. Real bits go out one clock later with their position in the destuffed frame and their position in the raw stream. A removed stuff bit shows up as a separate one-cycle strobe that carries its value. A sixth identical bit in a row is reported as a stuff error.

The receiver pulses `frame_start` at the start-of-frame bit. This empties the run history and both position counters. It can be given alone or in the same cycle as the first raw bit. The parser drops `stuff_on` from the CRC delimiter onward, because the fixed-form tail of a frame carries no stuff bits. From then on every bit is forwarded unchanged. CRC checking and field decoding belong to later stages.

Top module: `can_destuff`

## Requirements
- R1: After reset all outputs are 0, and the first raw bit accepted after reset has raw position 0 and destuffed position 0.
- R2: A raw bit that is neither a stuff bit nor in error appears one clock later with `bit_vld`=1, `bit_val` equal to the bit, and `bit_idx` one higher than for the previous forwarded bit of the same frame (0 for the first).
- R3: With `stuff_on`=1, a raw bit is a stuff bit when the five raw bits before it in the frame are all equal and it has the opposite value. One clock later `stuff_pulse`=1 and `stuff_val` is the bit, and `bit_vld`=0.
- R4: The run history holds raw bits including stuff bits, so a removed stuff bit counts as the first bit of the next run of five.
- R5: `raw_idx` advances for every raw bit, stuff bits included. `bit_idx` does not advance for a stuff bit.
- R6: With `stuff_on`=1, a raw bit equal to each of the five raw bits before it raises `stuff_err` for one clock, together with `bit_vld`. The bit is still forwarded.
- R7: `frame_start`=1 clears the history and both positions. A raw bit given in the same cycle becomes raw and destuffed bit 0 of the new frame, with an empty history.
- R8: With `stuff_on`=0, every raw bit is forwarded, and neither `stuff_pulse` nor `stuff_err` is raised. The bit is still entered into the run history.
- R9: In a clock where `raw_vld`=0, the next clock shows `bit_vld`, `stuff_pulse` and `stuff_err` at 0, and `bit_val`, `stuff_val`, `bit_idx` and `raw_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Start-of-frame clear of history and positions |
| stuff_on | input | 1 | 1: detect and remove stuff bits; 0: forward all bits |
| raw_vld | input | 1 | A raw sampled bit is present |
| raw_bit | input | 1 | Raw sampled bit value (0 dominant, 1 recessive) |
| bit_vld | output | 1 | Destuffed frame bit strobe |
| bit_val | output | 1 | Destuffed frame bit value |
| bit_idx | output | IDX_W | Position of the bit in the destuffed frame |
| raw_idx | output | RAW_W | Raw stream position of the latest bit or stuff bit |
| stuff_pulse | output | 1 | A stuff bit was removed |
| stuff_val | output | 1 | Value of the removed stuff bit |
| stuff_err | output | 1 | Six identical raw bits seen while stuffing is on |

## Verification
Every result is due exactly one clock edge after the edge that sampled `raw_vld`. It stays on the outputs until the following edge, because all outputs come straight from registers. The bench changes inputs on the falling edge. It then waits for one rising edge and compares the complete output vector at the next falling edge, before it drives the next bit. This includes idle cycles, where the strobes must be low and the held fields unchanged. The run and position model in the bench is updated in the same step, so each comparison covers exactly one raw bit.

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;
  typedef struct packed {
    logic stuff;
    logic err;
  } bit_class_t;
endpackage

// File: rtl/destuff_hist.sv
module destuff_hist #(
  parameter int RUN_LEN = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               shift,
  input  logic               bit_in,
  output logic [RUN_LEN-1:0] prev,
  output logic               full
);
  localparam int FILL_W = $clog2(RUN_LEN + 1);

  logic [RUN_LEN-1:0] hist_q;
  logic [FILL_W-1:0]  fill_q;
  logic [FILL_W-1:0]  fill_eff;

  // history as seen by the bit in this cycle (a same-cycle clear empties it)
  assign prev     = clr ? '0 : hist_q;
  assign fill_eff = clr ? '0 : fill_q;
  assign full     = (fill_eff == FILL_W'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift) begin
      hist_q <= {prev[RUN_LEN-2:0], bit_in};
      fill_q <= full ? fill_eff : fill_eff + 1'b1;
    end else if (clr) begin
      hist_q <= '0;
      fill_q <= '0;
    end
  end
endmodule

// File: rtl/destuff_classify.sv
module destuff_classify
  import can_destuff_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic [RUN_LEN-1:0] prev,
  input  logic               full,
  input  logic               en,
  input  logic               bit_in,
  output bit_class_t         cls
);
  logic all_zero, all_one;

  assign all_zero = ~|prev;
  assign all_one  = &prev;

  always_comb begin
    cls.stuff = en & full & (bit_in ? all_zero : all_one);
    cls.err   = en & full & (bit_in ? all_one : all_zero);
  end
endmodule

// File: rtl/destuff_count.sv
module destuff_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cur
);
  logic [W-1:0] cnt_q;

  assign cur = clr ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (inc) cnt_q <= cur + 1'b1;
    else if (clr) cnt_q <= '0;
  end
endmodule

// File: rtl/can_destuff.sv
module can_destuff
  import can_destuff_pkg::*;
#(
  parameter int RUN_LEN = 5,
  parameter int IDX_W   = 8,
  parameter int RAW_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             stuff_on,
  input  logic             raw_vld,
  input  logic             raw_bit,
  output logic             bit_vld,
  output logic             bit_val,
  output logic [IDX_W-1:0] bit_idx,
  output logic [RAW_W-1:0] raw_idx,
  output logic             stuff_pulse,
  output logic             stuff_val,
  output logic             stuff_err
);
  logic [RUN_LEN-1:0] prev;
  logic               full;
  bit_class_t         cls;
  logic [IDX_W-1:0]   dat_cur;
  logic [RAW_W-1:0]   raw_cur;
  logic               is_data;

  destuff_hist #(.RUN_LEN(RUN_LEN)) u_hist (
    .clk(clk), .rst(rst), .clr(frame_start), .shift(raw_vld),
    .bit_in(raw_bit), .prev(prev), .full(full)
  );

  destuff_classify #(.RUN_LEN(RUN_LEN)) u_cls (
    .prev(prev), .full(full), .en(stuff_on), .bit_in(raw_bit), .cls(cls)
  );

  assign is_data = raw_vld & ~cls.stuff;

  destuff_count #(.W(RAW_W)) u_raw_cnt (
    .clk(clk), .rst(rst), .clr(frame_start), .inc(raw_vld), .cur(raw_cur)
  );

  destuff_count #(.W(IDX_W)) u_dat_cnt (
    .clk(clk), .rst(rst), .clr(frame_start), .inc(is_data), .cur(dat_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_vld     <= 1'b0;
      bit_val     <= 1'b0;
      bit_idx     <= '0;
      raw_idx     <= '0;
      stuff_pulse <= 1'b0;
      stuff_val   <= 1'b0;
      stuff_err   <= 1'b0;
    end else begin
      bit_vld     <= is_data;
      stuff_pulse <= raw_vld & cls.stuff;
      stuff_err   <= raw_vld & cls.err;
      if (raw_vld) raw_idx <= raw_cur;
      if (is_data) begin
        bit_val <= raw_bit;
        bit_idx <= dat_cur;
      end
      if (raw_vld & cls.stuff) stuff_val <= raw_bit;
    end
  end
endmodule

// File: rtl/can_destuff_chk.sv
module can_destuff_chk (
  input logic clk,
  input logic rst,
  input logic stuff_on,
  input logic raw_vld,
  input logic raw_bit,
  input logic bit_vld,
  input logic stuff_pulse,
  input logic stuff_val,
  input logic stuff_err
);
  // R2 / R3: each raw bit yields exactly one of forwarded bit or stuff strobe
  a_r2_one_result: assert property (@(posedge clk) disable iff (rst)
    raw_vld |=> (bit_vld != stuff_pulse));

  // R9: no strobes after an idle cycle
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    !raw_vld |=> (!bit_vld && !stuff_pulse && !stuff_err));

  // R6: an error bit is still forwarded
  a_r6_err_fwd: assert property (@(posedge clk) disable iff (rst)
    stuff_err |-> bit_vld);

  // R8: stuffing off forwards every bit without error
  a_r8_off_fwd: assert property (@(posedge clk) disable iff (rst)
    (raw_vld && !stuff_on) |=> (bit_vld && !stuff_err));

  // R3: reported stuff value is the raw bit of the previous cycle
  a_r3_stuff_val: assert property (@(posedge clk) disable iff (rst)
    stuff_pulse |-> (stuff_val == $past(raw_bit)));
endmodule

bind can_destuff can_destuff_chk u_chk (
  .clk(clk), .rst(rst), .stuff_on(stuff_on), .raw_vld(raw_vld),
  .raw_bit(raw_bit), .bit_vld(bit_vld), .stuff_pulse(stuff_pulse),
  .stuff_val(stuff_val), .stuff_err(stuff_err)
);

// File: tb/sim_can_destuff.sv
module sim_can_destuff;
  localparam int IDX_W = 8;
  localparam int RAW_W = 8;
  localparam int VW    = 5 + IDX_W + RAW_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, stuff_on = 1'b1, raw_vld = 1'b0, raw_bit = 1'b0;
  logic bit_vld, bit_val, stuff_pulse, stuff_val, stuff_err;
  logic [IDX_W-1:0] bit_idx;
  logic [RAW_W-1:0] raw_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int   m_run = 0, m_dat = 0, m_raw = 0;
  logic m_last = 1'b0;
  bit   m_run_has_stuff = 0;
  logic e_bval = 1'b0, e_sval = 1'b0;
  logic [IDX_W-1:0] e_bidx = '0;
  logic [RAW_W-1:0] e_ridx = '0;

  always #5 clk = ~clk;

  can_destuff #(.RUN_LEN(5), .IDX_W(IDX_W), .RAW_W(RAW_W)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .stuff_on(stuff_on),
    .raw_vld(raw_vld), .raw_bit(raw_bit), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_idx(bit_idx), .raw_idx(raw_idx), .stuff_pulse(stuff_pulse),
    .stuff_val(stuff_val), .stuff_err(stuff_err)
  );

  function automatic logic [VW-1:0] act_vec();
    return {bit_vld, stuff_pulse, stuff_err, bit_val, stuff_val, bit_idx, raw_idx};
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] exp);
    n_chk++;
    if (act_vec() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act_vec(), exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where the result is due
  task automatic step(input logic vld, input logic sof, input logic en, input logic b);
    bit e_stuff, e_err;
    string tag;
    e_stuff = 0; e_err = 0;
    frame_start = sof; stuff_on = en; raw_vld = vld; raw_bit = b;
    if (sof) begin
      m_run = 0; m_dat = 0; m_raw = 0; m_last = 1'b0; m_run_has_stuff = 0;
    end
    if (!vld) tag = sof ? "R7" : "R9";
    else begin
      e_stuff = en && (m_run >= 5) && (b != m_last);
      e_err   = en && (m_run >= 5) && (b == m_last);
      e_ridx  = RAW_W'(m_raw);
      if (e_stuff) e_sval = b;
      else begin
        e_bval = b;
        e_bidx = IDX_W'(m_dat);
        m_dat++;
      end
      if (!en) tag = "R8";
      else if (e_err) tag = "R6";
      else if (e_stuff) tag = m_run_has_stuff ? "R4" : "R3";
      else if (sof) tag = "R7";
      else tag = "R2";
      if (e_stuff) tag = {tag, "/R5"};
      if (m_run > 0 && b == m_last) m_run++;
      else begin
        m_run = 1;
        m_run_has_stuff = e_stuff;
      end
      m_last = b;
      m_raw++;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, {vld && !e_stuff, vld && e_stuff, e_err, e_bval, e_sval, e_bidx, e_ridx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", '0);
    // first bit after reset without a start pulse: positions 0 (R1)
    step(1'b1, 1'b0, 1'b1, 1'b1);
    for (int mode = 0; mode < 3; mode++) begin
      for (int p = 0; p < 1024; p++) begin
        if (p % 4 == 1) step(1'b0, 1'b1, 1'b1, 1'b0); // clear alone (R7)
        for (int i = 0; i < 10; i++) begin
          logic en;
          logic b;
          b  = p[9-i];
          en = (mode == 0) ? 1'b1 : (mode == 1) ? (i >= 4) : (i < 6);
          if (p % 3 == 0 && i == 4) step(1'b0, 1'b0, en, ~b); // idle (R9)
          step(1'b1, (i == 0) && (p % 4 != 1), en, b);
        end
      end
    end
    raw_vld = 1'b0; frame_start = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule